// File: doc/BRIEF.md
# SPI Command Instruction Sequencer

This block is an SPI master that is steered entirely by a stream of 16-bit instructions rather than by fixed per-transfer registers. Each instruction can move a burst of words on the serial lines, drive the chip-select lines, load one of three internal settings (clock divider, mode bits, word width), pause for a number of SPI clock periods, change the chip-select polarity mask, or emit a numbered sync marker that software uses to learn how far a program has run.

Instructions arrive on a valid/ready stream. Transmit words come from a second valid/ready stream, and received words leave on a third. The serial side is SCLK, SDO with an output enable for three-wire operation, SDI and an active-low chip-select vector. The block runs on one reference clock, and SCLK is derived from it by a programmable divider.

Top module: `spi_cmd_sequencer`

## Requirements
- R1: Instruction fields are opcode = bits 15:12, argument A = bits 11:8, argument B = bits 7:0. Opcodes: 0 burst, 1 select drive, 2 setting load, 3 misc, 4 polarity mask. An instruction is taken only while cmdReady is high. cmdReady drops in the cycle after a burst or a pause is accepted and stays low until that instruction has finished.
- R2: After reset csN is all ones, sclk and sdo are 0, sdoOe is 1, rxValid and syncValid are 0, cmdReady is 1. The divider setting resets to 0, the mode bits to 0 and the word width to 8.
- R3: A select-drive instruction sets csN to B XOR the stored polarity mask. csN changes in the cycle after the instruction is accepted and at no other time.
- R4: A polarity-mask instruction stores B as the mask and leaves csN unchanged. The mask takes effect only when the next select-drive instruction runs.
- R5: A setting load with A = 0 sets the divider value D. Each SCLK half period is then D+1 reference cycles.
- R6: A setting load with A = 1 sets the mode bits. Bit 1 (CPOL) is the SCLK idle level. Bit 0 (CPHA) clear samples SDI on leading edges, and bit 0 set samples on trailing edges. Bit 3 sets the SDO idle level. Bit 2 (three-wire) drives sdoOe low for the whole of a burst whose write flag is clear.
- R7: A setting load with A = 2 sets the word width W, from 1 to 32 bits. Each word makes exactly 2W SCLK transitions, shifts out MSB first and ends with SCLK at its idle level.
- R8: A burst moves B+1 words. Flag A bit 0 takes one transmit word per serial word, and flag A bit 1 gives one received word per serial word, right-aligned in rxData.
- R9: In a burst with the write flag clear, SDO stays at its idle level and no transmit word is taken. In a burst with the read flag clear, no receive word is produced.
- R10: A misc instruction with A = 1 pauses for B+1 SCLK periods. cmdReady stays low for exactly 2(B+1)(D+1) cycles, and SCLK does not move.
- R11: A misc instruction with A = 0 raises syncValid for exactly one cycle, in the cycle after it is accepted, with syncId = B.
- R12: Between words, the burst waits while a needed transmit word is missing or the previous receive word has not been taken. During the wait SCLK holds its idle level, and rxData stays stable while rxValid is high and rxReady is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low reset |
| cmdValid | input | 1 | Instruction offered |
| cmdReady | output | 1 | Instruction taken when high together with cmdValid |
| cmdData | input | 16 | Instruction word |
| txValid | input | 1 | Transmit word offered |
| txReady | output | 1 | Transmit word taken |
| txData | input | DATA_W | Transmit word, right-aligned |
| rxValid | output | 1 | Received word available |
| rxReady | input | 1 | Received word taken |
| rxData | output | DATA_W | Received word, right-aligned |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdoOe | output | 1 | SDO output enable (low while SDO is released in three-wire reads) |
| sdi | input | 1 | Serial data in |
| csN | output | CS_W | Chip selects, low selects |
| syncValid | output | 1 | Sync marker pulse |
| syncId | output | 8 | Sync marker number |

## Verification
On every cycle, the bound checker covers the handshake-level rules. cmdReady falls after a burst or pause is accepted. csN moves only after a select-drive instruction. A sync pulse appears exactly when a sync instruction was taken and carries its number. A held receive word stays stable. Serial timing, which covers half-period length, transition count per word, MSB-first order under each clock mode, idle levels, pause length and the effect of the polarity mask, can only be shown by the bench scenarios. The bench loops SDO back to SDI, measures SCLK and compares the received words.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  localparam logic [3:0] OP_BURST = 4'd0;
  localparam logic [3:0] OP_SELECT = 4'd1;
  localparam logic [3:0] OP_SETTING = 4'd2;
  localparam logic [3:0] OP_MISC = 4'd3;
  localparam logic [3:0] OP_POLMASK = 4'd4;

  localparam logic [3:0] MISC_MARK = 4'd0;
  localparam logic [3:0] MISC_PAUSE = 4'd1;

  // control -> datapath strobes
  typedef struct packed {
    logic settingWr;
    logic [1:0] settingSel;
    logic [7:0] arg;
    logic selLoad;
    logic maskLoad;
    logic wordStart;
    logic wordWr;
    logic wordRd;
    logic burstOn;
    logic pauseOn;
  } seqStrobe_t;
endpackage

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_seq_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic cmdValid,
  output logic cmdReady,
  input  logic [15:0] cmdData,
  input  logic txValid,
  output logic txReady,
  input  logic rxPending,
  input  logic tick,
  input  logic wordDone,
  output seqStrobe_t strb,
  output logic syncValid,
  output logic [7:0] syncId
);
  typedef enum logic [1:0] {ST_IDLE, ST_BURST, ST_PAUSE} seqState_t;

  seqState_t state;
  logic [7:0] wordsLeft;
  logic wrFlag, rdFlag, inWord;
  logic [8:0] pauseCnt;
  logic [3:0] opc, argA;
  logic [7:0] argB;
  logic accept, canStart;

  assign opc = cmdData[15:12];
  assign argA = cmdData[11:8];
  assign argB = cmdData[7:0];
  assign cmdReady = (state == ST_IDLE);
  assign accept = cmdValid && cmdReady;
  assign canStart = (state == ST_BURST) && !inWord &&
                    (!wrFlag || txValid) && (!rdFlag || !rxPending);
  assign txReady = canStart && wrFlag;

  always_comb begin
    strb = '0;
    strb.settingWr = accept && (opc == OP_SETTING) && (argA < 4'd3);
    strb.settingSel = argA[1:0];
    strb.arg = argB;
    strb.selLoad = accept && (opc == OP_SELECT);
    strb.maskLoad = accept && (opc == OP_POLMASK);
    strb.wordStart = canStart;
    strb.wordWr = wrFlag;
    strb.wordRd = rdFlag;
    strb.burstOn = (state == ST_BURST);
    strb.pauseOn = (state == ST_PAUSE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      wordsLeft <= '0;
      wrFlag <= 1'b0;
      rdFlag <= 1'b0;
      inWord <= 1'b0;
      pauseCnt <= '0;
      syncValid <= 1'b0;
      syncId <= '0;
    end else begin
      syncValid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            if (opc == OP_BURST) begin
              wordsLeft <= argB;
              wrFlag <= argA[0];
              rdFlag <= argA[1];
              inWord <= 1'b0;
              state <= ST_BURST;
            end else if (opc == OP_MISC && argA == MISC_PAUSE) begin
              pauseCnt <= {argB, 1'b1};
              state <= ST_PAUSE;
            end else if (opc == OP_MISC && argA == MISC_MARK) begin
              syncValid <= 1'b1;
              syncId <= argB;
            end
          end
        end
        ST_BURST: begin
          if (canStart) inWord <= 1'b1;
          if (wordDone) begin
            inWord <= 1'b0;
            if (wordsLeft == '0) state <= ST_IDLE;
            else wordsLeft <= wordsLeft - 8'd1;
          end
        end
        ST_PAUSE: begin
          if (tick) begin
            if (pauseCnt == '0) state <= ST_IDLE;
            else pauseCnt <= pauseCnt - 9'd1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_seq_datapath.sv
module spi_seq_datapath
  import spi_seq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CS_W = 8
) (
  input  logic clk,
  input  logic rstN,
  input  seqStrobe_t strb,
  input  logic [DATA_W-1:0] txData,
  input  logic sdi,
  input  logic rxReady,
  output logic tick,
  output logic wordDone,
  output logic sclk,
  output logic sdo,
  output logic sdoOe,
  output logic [CS_W-1:0] csN,
  output logic rxValid,
  output logic [DATA_W-1:0] rxData
);
  localparam int WB = $clog2(DATA_W + 1);
  localparam int EB = WB + 1;
  localparam logic [WB-1:0] WIDTH_RESET = WB'(8);

  logic [7:0] divVal, divCnt;
  logic [3:0] modeBits;
  logic [WB-1:0] widthCfg, effW;
  logic [CS_W-1:0] polMask;
  logic busy, phase;
  logic [EB-1:0] edgeCnt, lastEdgeVal;
  logic [DATA_W-1:0] txSh, rxSh, rxNext;
  logic lastEdge, leading, doShift, doSample, running;
  logic cpha, cpol, threeWire, idleHigh;

  assign cpha = modeBits[0];
  assign cpol = modeBits[1];
  assign threeWire = modeBits[2];
  assign idleHigh = modeBits[3];

  // settings and chip selects
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divVal <= '0;
      modeBits <= '0;
      widthCfg <= WIDTH_RESET;
      polMask <= '0;
      csN <= '1;
    end else begin
      if (strb.settingWr) begin
        case (strb.settingSel)
          2'd0: divVal <= strb.arg;
          2'd1: modeBits <= strb.arg[3:0];
          default: widthCfg <= WB'(strb.arg);
        endcase
      end
      if (strb.maskLoad) polMask <= strb.arg[CS_W-1:0];
      if (strb.selLoad) csN <= strb.arg[CS_W-1:0] ^ polMask;
    end
  end

  always_comb begin
    effW = (widthCfg == '0 || widthCfg > WB'(DATA_W)) ? WB'(DATA_W) : widthCfg;
    lastEdgeVal = {effW, 1'b0} - EB'(1);
  end

  // reference clock divider, shared by shifting and pausing
  assign running = busy || strb.pauseOn;
  assign tick = running && (divCnt == divVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else if (!running || tick) divCnt <= '0;
    else divCnt <= divCnt + 8'd1;
  end

  // shift engine
  assign leading = !edgeCnt[0];
  assign lastEdge = (edgeCnt == lastEdgeVal);
  assign doShift = tick && busy && (cpha ? (leading && edgeCnt != '0) : !leading);
  assign doSample = tick && busy && (cpha ? !leading : leading);
  assign wordDone = tick && busy && lastEdge;
  assign rxNext = doSample ? {rxSh[DATA_W-2:0], sdi} : rxSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      phase <= 1'b0;
      edgeCnt <= '0;
      txSh <= '0;
      rxSh <= '0;
      rxValid <= 1'b0;
      rxData <= '0;
    end else begin
      if (strb.wordStart) begin
        busy <= 1'b1;
        phase <= 1'b0;
        edgeCnt <= '0;
        txSh <= txData << (DATA_W - int'(effW));
        rxSh <= '0;
      end else if (tick && busy) begin
        phase <= ~phase;
        edgeCnt <= edgeCnt + EB'(1);
        rxSh <= rxNext;
        if (doShift) txSh <= {txSh[DATA_W-2:0], 1'b0};
        if (lastEdge) busy <= 1'b0;
      end
      if (wordDone && strb.wordRd) begin
        rxValid <= 1'b1;
        rxData <= rxNext;
      end else if (rxValid && rxReady) begin
        rxValid <= 1'b0;
      end
    end
  end

  assign sclk = cpol ^ phase;
  assign sdo = (busy && strb.wordWr) ? txSh[DATA_W-1] : idleHigh;
  assign sdoOe = !(threeWire && strb.burstOn && !strb.wordWr);
endmodule

// File: rtl/spi_cmd_sequencer.sv
module spi_cmd_sequencer
  import spi_seq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CS_W = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic cmdValid,
  output logic cmdReady,
  input  logic [15:0] cmdData,
  input  logic txValid,
  output logic txReady,
  input  logic [DATA_W-1:0] txData,
  output logic rxValid,
  input  logic rxReady,
  output logic [DATA_W-1:0] rxData,
  output logic sclk,
  output logic sdo,
  output logic sdoOe,
  input  logic sdi,
  output logic [CS_W-1:0] csN,
  output logic syncValid,
  output logic [7:0] syncId
);
  seqStrobe_t strb;
  logic tick, wordDone;

  spi_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdData(cmdData),
    .txValid(txValid), .txReady(txReady),
    .rxPending(rxValid), .tick(tick), .wordDone(wordDone),
    .strb(strb), .syncValid(syncValid), .syncId(syncId)
  );

  spi_seq_datapath #(.DATA_W(DATA_W), .CS_W(CS_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .txData(txData), .sdi(sdi),
    .rxReady(rxReady), .tick(tick), .wordDone(wordDone),
    .sclk(sclk), .sdo(sdo), .sdoOe(sdoOe), .csN(csN),
    .rxValid(rxValid), .rxData(rxData)
  );
endmodule

// File: rtl/spi_seq_chk.sv
module spi_seq_chk #(
  parameter int DATA_W = 32,
  parameter int CS_W = 8
) (
  input logic clk,
  input logic rstN,
  input logic cmdValid,
  input logic cmdReady,
  input logic [15:0] cmdData,
  input logic rxValid,
  input logic rxReady,
  input logic [DATA_W-1:0] rxData,
  input logic [CS_W-1:0] csN,
  input logic syncValid,
  input logic [7:0] syncId
);
  logic taken;
  assign taken = cmdValid && cmdReady;

  // R1
  burst_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    taken && cmdData[15:12] == 4'd0 |=> !cmdReady);

  // R10
  pause_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    taken && cmdData[15:8] == 8'h31 |=> !cmdReady);

  // R3
  select_only_on_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(taken && cmdData[15:12] == 4'd1) |=> $stable(csN));

  // R11
  mark_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    taken && cmdData[15:8] == 8'h30 |=> syncValid && syncId == $past(cmdData[7:0]));

  // R11
  mark_only_on_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(taken && cmdData[15:8] == 8'h30) |=> !syncValid);

  // R12
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && !rxReady |=> rxValid && $stable(rxData));
endmodule

bind spi_cmd_sequencer spi_seq_chk #(.DATA_W(DATA_W), .CS_W(CS_W)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
  .cmdData(cmdData), .rxValid(rxValid), .rxReady(rxReady), .rxData(rxData),
  .csN(csN), .syncValid(syncValid), .syncId(syncId)
);

// File: tb/spi_cmd_sequencer_tb.sv
module spi_cmd_sequencer_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [15:0] cmdData = '0;
  logic cmdReady, txReady, txValid, rxValid, rxReady;
  logic [31:0] txData, rxData;
  logic sclk, sdo, sdoOe, sdi, syncValid;
  logic [7:0] csN, syncId;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [31:0] txMem [0:7];
  int txIdx = 0;
  int txLimit = 0;
  bit rxAccept = 1'b1;
  logic [31:0] rxLog [0:15];
  int rxCnt = 0;
  int cyc = 0;
  int edges = 0;
  int lastTog = 0;
  int lastGap = 0;
  logic sclkPrev = 1'b0;

  always #5 clk = ~clk;

  assign sdi = sdo;
  assign txValid = (txIdx < txLimit);
  assign txData = txMem[txIdx[2:0]];
  assign rxReady = rxAccept;

  spi_cmd_sequencer u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdData(cmdData), .txValid(txValid), .txReady(txReady), .txData(txData),
    .rxValid(rxValid), .rxReady(rxReady), .rxData(rxData),
    .sclk(sclk), .sdo(sdo), .sdoOe(sdoOe), .sdi(sdi), .csN(csN),
    .syncValid(syncValid), .syncId(syncId)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    sclkPrev <= sclk;
    if (rstN && sclk !== sclkPrev) begin
      edges <= edges + 1;
      lastGap <= cyc - lastTog;
      lastTog <= cyc;
    end
    if (rstN && txValid && txReady) txIdx <= txIdx + 1;
    if (rstN && rxValid && rxReady) begin
      rxLog[rxCnt[3:0]] <= rxData;
      rxCnt <= rxCnt + 1;
    end
  end

  typedef struct packed {
    logic [7:0] div;
    logic [7:0] width;
    logic [3:0] mode;
    logic [31:0] data;
    logic [31:0] expRx;
  } vec_t;

  localparam vec_t VECS [0:6] = '{
    '{8'd0, 8'd8,  4'h0, 32'h0000_00A5, 32'h0000_00A5},
    '{8'd1, 8'd8,  4'h1, 32'h0000_003C, 32'h0000_003C},
    '{8'd2, 8'd12, 4'h2, 32'h0000_FABC, 32'h0000_0ABC},
    '{8'd0, 8'd16, 4'h3, 32'h1234_8001, 32'h0000_8001},
    '{8'd3, 8'd5,  4'h0, 32'h0000_0013, 32'h0000_0013},
    '{8'd0, 8'd32, 4'h8, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    '{8'd1, 8'd1,  4'h3, 32'h0000_0001, 32'h0000_0001}
  };

  function automatic logic [15:0] mk(input logic [3:0] op, input logic [3:0] a, input logic [7:0] b);
    return {op, a, b};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendCmd(input logic [15:0] c);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdData = c;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitIdle();
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int e0, r0, t0, cnt;
    for (int i = 0; i < 8; i++) txMem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R2 reset state
    check("R2 csN", {24'd0, csN}, 32'hFF);
    check("R2 idle lines", {28'd0, sclk, sdo, sdoOe, cmdReady}, 32'h3);
    check("R2 valids", {30'd0, rxValid, syncValid}, 32'h0);

    // table of bursts, write+read with loopback
    for (int i = 0; i < 7; i++) begin
      sendCmd(mk(4'd2, 4'd0, VECS[i].div));
      sendCmd(mk(4'd2, 4'd1, {4'd0, VECS[i].mode}));
      sendCmd(mk(4'd2, 4'd2, VECS[i].width));
      sendCmd(mk(4'd1, 4'd0, 8'hFE));
      txMem[txIdx[2:0]] = VECS[i].data;
      txLimit = txIdx + 1;
      e0 = edges;
      r0 = rxCnt;
      sendCmd(mk(4'd0, 4'd3, 8'd0));
      waitIdle();
      @(negedge clk);
      check($sformatf("R7 vec%0d rx word", i), rxLog[r0[3:0]], VECS[i].expRx);
      check($sformatf("R8 vec%0d rx count", i), rxCnt - r0, 1);
      check($sformatf("R7 vec%0d transitions", i), edges - e0, 2 * VECS[i].width);
      check($sformatf("R5 vec%0d half period", i), lastGap, VECS[i].div + 1);
      check($sformatf("R6 vec%0d sclk idle", i), {31'd0, sclk}, {31'd0, VECS[i].mode[1]});
      check($sformatf("R6 vec%0d sdo idle", i), {31'd0, sdo}, {31'd0, VECS[i].mode[3]});
      check($sformatf("R3 vec%0d csN", i), {24'd0, csN}, 32'hFE);
      sendCmd(mk(4'd1, 4'd0, 8'hFF));
    end

    // R11 sync marker
    sendCmd(mk(4'd3, 4'd0, 8'h5A));
    check("R11 pulse", {24'd0, syncId}, {24'd0, syncValid ? 8'h5A : 8'h00});
    @(negedge clk);
    check("R11 single cycle", {31'd0, syncValid}, 32'd0);

    // R4 polarity mask stored, applied on next select drive
    sendCmd(mk(4'd4, 4'd0, 8'h01));
    check("R4 mask alone", {24'd0, csN}, 32'hFF);
    sendCmd(mk(4'd1, 4'd0, 8'hFF));
    check("R4 mask applied", {24'd0, csN}, 32'hFE);
    sendCmd(mk(4'd1, 4'd0, 8'hF0));
    check("R3 xor", {24'd0, csN}, 32'hF1);
    sendCmd(mk(4'd4, 4'd0, 8'h00));
    sendCmd(mk(4'd1, 4'd0, 8'hFF));
    check("R3 deselect", {24'd0, csN}, 32'hFF);

    // R10 pause timing
    sendCmd(mk(4'd2, 4'd0, 8'd1));
    e0 = edges;
    @(negedge clk);
    cmdValid = 1'b1;
    cmdData = mk(4'd3, 4'd1, 8'd3);
    @(negedge clk);
    cmdValid = 1'b0;
    cnt = 0;
    while (!cmdReady) begin cnt++; @(negedge clk); end
    check("R10 pause 3 div 1", cnt, 16);
    check("R10 sclk still", edges - e0, 0);
    sendCmd(mk(4'd2, 4'd0, 8'd0));
    @(negedge clk);
    cmdValid = 1'b1;
    cmdData = mk(4'd3, 4'd1, 8'd0);
    @(negedge clk);
    cmdValid = 1'b0;
    cnt = 0;
    while (!cmdReady) begin cnt++; @(negedge clk); end
    check("R10 pause 0 div 0", cnt, 2);

    // R9 read-only burst, three-wire, SDO idle high
    sendCmd(mk(4'd2, 4'd1, 8'h0C));
    sendCmd(mk(4'd2, 4'd2, 8'd8));
    t0 = txIdx;
    txLimit = txIdx + 4;
    r0 = rxCnt;
    sendCmd(mk(4'd0, 4'd2, 8'd0));
    check("R6 three-wire release", {30'd0, sdoOe, sdo}, 32'h1);
    waitIdle();
    @(negedge clk);
    check("R9 rx idle-high ones", rxLog[r0[3:0]], 32'hFF);
    check("R9 no tx taken", txIdx - t0, 0);
    check("R6 sdoOe restored", {31'd0, sdoOe}, 32'd1);

    // R9 write-only burst
    sendCmd(mk(4'd2, 4'd1, 8'h00));
    txMem[txIdx[2:0]] = 32'h55;
    r0 = rxCnt;
    t0 = txIdx;
    sendCmd(mk(4'd0, 4'd1, 8'd0));
    waitIdle();
    @(negedge clk);
    check("R9 no rx word", rxCnt - r0, 0);
    check("R8 one tx taken", txIdx - t0, 1);
    txLimit = txIdx;

    // R12 receive stall across a 3-word burst
    sendCmd(mk(4'd2, 4'd2, 8'd4));
    txMem[(txIdx + 0) % 8] = 32'h3;
    txMem[(txIdx + 1) % 8] = 32'h5;
    txMem[(txIdx + 2) % 8] = 32'h9;
    txLimit = txIdx + 3;
    rxAccept = 1'b0;
    r0 = rxCnt;
    e0 = edges;
    sendCmd(mk(4'd0, 4'd3, 8'd2));
    repeat (40) @(negedge clk);
    check("R12 held word", {rxValid, rxData[30:0]}, 32'h8000_0003);
    check("R12 stall transitions", edges - e0, 8);
    check("R12 sclk idle", {30'd0, sclk, cmdReady}, 32'd0);
    rxAccept = 1'b1;
    waitIdle();
    @(negedge clk);
    check("R8 three words", rxCnt - r0, 3);
    check("R8 word 2", rxLog[(r0 + 1) % 16], 32'h5);
    check("R8 word 3", rxLog[(r0 + 2) % 16], 32'h9);

    // R12 transmit stall
    txMem[txIdx[2:0]] = 32'hA;
    txLimit = txIdx;
    e0 = edges;
    r0 = rxCnt;
    sendCmd(mk(4'd0, 4'd3, 8'd0));
    repeat (20) @(negedge clk);
    check("R12 tx stall", {30'd0, cmdReady, sclk}, 32'd0);
    check("R12 tx stall transitions", edges - e0, 0);
    txLimit = txIdx + 1;
    waitIdle();
    @(negedge clk);
    check("R12 after tx stall", rxLog[r0[3:0]], 32'hA);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule